// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit side of a small Ethernet MAC. Software fills one of two packet buffers over a 32-bit word bus, programs that buffer's byte count and then writes its control word. The control word does one of two jobs. With the send bit alone, the block streams the buffer's bytes out on a byte-wide valid/ready port. With the send and program bits together, it copies the first six buffer bytes into the station address register and emits nothing on the stream. Preamble, FCS and the PHY side are handled downstream.

Each buffer occupies its own half of the word address space. The two halves have the same layout: packet words from word 0 upward, then a length word, then a control word in the top slot. The slot just below the control word holds the global interrupt enable in the buffer 0 half only. When an operation ends, the block clears the request bits and can pulse an interrupt.

The stream obeys the usual back-pressure rules. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the block keeps `tx_valid` asserted and holds `tx_data` and `tx_last`. `tx_ready` may stay high when nothing is offered. Bus reads return their data one cycle after the read strobe.

Top module: `etx_dual_tx`

## Requirements
- R1: Word address bit 9 selects the buffer and bits 8:0 the word within it. Word 509 (byte offset 0x7F4) is the length, word 511 (0x7FC) is the control word, and word 510 (0x7F8) is the global enable, present only in buffer 0. Buffer 1 mirrors this layout 0x800 bytes higher. A read returns the stored word in the cycle after the strobe.
- R2: A control write with bit 0 (send) = 1 and bit 1 (program) = 0 transmits exactly as many bytes as the low 12 bits of that buffer's length word. The count may be anything up to the buffer's capacity.
- R3: Byte n of a frame is taken from word n/4 of the buffer, bits [31-8*(n%4) -: 8], so the most significant byte leaves first. `tx_last` is high on the final byte only.
- R4: While `tx_valid` is high and `tx_ready` is low, the block keeps `tx_valid` and `tx_last` steady and holds the byte on offer.
- R5: A control write with bit 0 = 1 and bit 1 = 1 sets the station address to {word 0, word 1[31:16]} of that buffer and puts no byte on the stream.
- R6: Bits 0 and 1 read back as written while the operation is in progress and read 0 once it completes. All other control bits keep their written value. A control write with bit 0 = 0 stores bits 0 and 1 as 0 and starts nothing.
- R7: In the cycle after an operation completes, `irq` is high for exactly one cycle, and only if bit 3 of that buffer's control word and bit 31 of the global enable are both 1. Buffer 1 uses the same global enable.
- R8: A control write to a buffer whose bit 0 is still set is ignored in full: no bit changes and no second operation starts.
- R9: A request made on one buffer while the other buffer's operation runs waits and is served once that operation completes. If both buffers are pending while the engine is idle, buffer 0 goes first.
- R10: A send with a byte count of 0 completes without putting any byte on the stream. It still clears the request bits and follows R7.
- R11: After reset, all control, length and enable words read 0, the station address is 0, and `tx_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Word write strobe |
| bus_rd_en | input | 1 | Word read strobe |
| bus_addr | input | 10 | Word address (bit 9 selects the buffer) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd_en` |
| tx_valid | output | 1 | A frame byte is on offer |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Marks the final byte of a frame |
| station_addr | output | 48 | Station MAC address register |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Two things can land on the same clock edge: the final byte handshake of buffer 0, which completes that operation and clears its request bits, and a bus write that raises the send request on buffer 1. The bench arranges this by holding `tx_ready` low on a one-byte frame. It then releases `tx_ready` and issues the buffer 1 control write in the same cycle. The result passes only if both frames leave in order with the expected bytes and the block produces exactly two interrupt pulses.

// File: rtl/etx_pkg.sv
package etx_pkg;
  localparam int CTL_SEND = 0;
  localparam int CTL_PROG = 1;
  localparam int CTL_IEN  = 3;
  localparam int GIE_BIT  = 31;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SEND,
    ENG_ADDR_HI,
    ENG_ADDR_LO
  } eng_state_e;
endpackage

// File: rtl/etx_regbank.sv
module etx_regbank
  import etx_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  parameter int AW        = $clog2(2 * BUF_WORDS),
  parameter int LEN_W     = $clog2(4 * BUF_WORDS) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [AW-1:0]              bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [AW-1:0]              eng_raddr,
  output logic [31:0]                eng_rword,
  input  logic                       done_i,
  input  logic                       done_buf_i,
  output logic [1:0]                 req_send_o,
  output logic [1:0]                 req_prog_o,
  output logic [1:0]                 req_ien_o,
  output logic [1:0][LEN_W-1:0]      len_o,
  output logic                       gie_o
);
  localparam int IW      = AW - 1;
  localparam int LEN_IDX = BUF_WORDS - 3;
  localparam int GIE_IDX = BUF_WORDS - 2;
  localparam int CTL_IDX = BUF_WORDS - 1;

  logic [31:0]       pkt_mem [2*BUF_WORDS];
  logic [1:0][31:0]  ctl_q;
  logic [1:0][31:0]  len_q;
  logic [31:0]       gie_q;

  logic          sel_buf;
  logic [IW-1:0] sel_word;
  logic          hit_len, hit_ctl, hit_gie;

  assign sel_buf  = bus_addr[AW-1];
  assign sel_word = bus_addr[IW-1:0];
  assign hit_len  = (sel_word == IW'(LEN_IDX));
  assign hit_ctl  = (sel_word == IW'(CTL_IDX));
  assign hit_gie  = (sel_word == IW'(GIE_IDX)) && !sel_buf;

  // Packet store: everything that is not a control, length or enable word
  always_ff @(posedge clk) begin
    if (bus_wr_en && !hit_len && !hit_ctl && !hit_gie)
      pkt_mem[bus_addr] <= bus_wdata;
  end

  assign eng_rword = pkt_mem[eng_raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      len_q <= '0;
      gie_q <= '0;
    end else begin
      if (bus_wr_en) begin
        if (hit_ctl) begin
          if (!ctl_q[sel_buf][CTL_SEND])
            ctl_q[sel_buf] <= bus_wdata[CTL_SEND] ? bus_wdata
                                                  : (bus_wdata & ~32'h3);
        end else if (hit_len) begin
          len_q[sel_buf] <= bus_wdata;
        end else if (hit_gie) begin
          gie_q <= bus_wdata;
        end
      end
      if (done_i)
        ctl_q[done_buf_i][1:0] <= 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      if (hit_ctl)      bus_rdata <= ctl_q[sel_buf];
      else if (hit_len) bus_rdata <= len_q[sel_buf];
      else if (hit_gie) bus_rdata <= gie_q;
      else              bus_rdata <= pkt_mem[bus_addr];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_ctl_out
    assign req_send_o[b] = ctl_q[b][CTL_SEND];
    assign req_prog_o[b] = ctl_q[b][CTL_PROG];
    assign req_ien_o[b]  = ctl_q[b][CTL_IEN];
    assign len_o[b]      = len_q[b][LEN_W-1:0];
  end
  assign gie_o = gie_q[GIE_BIT];

  AST_CTL0_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0][CTL_SEND] && !(done_i && !done_buf_i) |=> $stable(ctl_q[0])); // R8
  AST_CTL1_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1][CTL_SEND] && !(done_i && done_buf_i) |=> $stable(ctl_q[1])); // R8
  AST_SEND0_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[0][CTL_SEND]) |-> $past(done_i && !done_buf_i)); // R6
  AST_SEND1_CLEARS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[1][CTL_SEND]) |-> $past(done_i && done_buf_i)); // R6
endmodule

// File: rtl/etx_engine.sv
module etx_engine
  import etx_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  parameter int AW        = $clog2(2 * BUF_WORDS),
  parameter int LEN_W     = $clog2(4 * BUF_WORDS) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            req_send_i,
  input  logic [1:0]            req_prog_i,
  input  logic [1:0]            req_ien_i,
  input  logic [1:0][LEN_W-1:0] len_i,
  input  logic                  gie_i,
  output logic [AW-1:0]         eng_raddr,
  input  logic [31:0]           eng_rword,
  output logic                  done_o,
  output logic                  done_buf_o,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_data,
  output logic                  tx_last,
  output logic [47:0]           mac_o,
  output logic                  irq_o
);
  localparam int IW = AW - 1;

  eng_state_e        state_q;
  logic              cur_buf_q;
  logic [LEN_W-1:0]  byte_cnt_q;
  logic [LEN_W-1:0]  len_lat_q;
  logic [31:0]       mac_hi_q;
  logic [47:0]       mac_q;
  logic              irq_q;

  logic              any_req, pick;
  logic              pick_prog;
  logic [LEN_W-1:0]  pick_len;
  logic [IW-1:0]     word_idx;

  // Buffer 0 wins when both are pending
  assign any_req   = |req_send_i;
  assign pick      = !req_send_i[0];
  assign pick_prog = req_prog_i[pick];
  assign pick_len  = len_i[pick];

  always_comb begin
    unique case (state_q)
      ENG_ADDR_HI: word_idx = '0;
      ENG_ADDR_LO: word_idx = IW'(1);
      default:     word_idx = byte_cnt_q[IW+1:2];
    endcase
  end
  assign eng_raddr = {cur_buf_q, word_idx};

  assign tx_valid = (state_q == ENG_SEND);
  assign tx_data  = eng_rword[8*(3 - int'(byte_cnt_q[1:0])) +: 8];
  assign tx_last  = tx_valid && (byte_cnt_q == len_lat_q - LEN_W'(1));

  assign done_o = (state_q == ENG_IDLE && any_req && !pick_prog && pick_len == '0)
               || (tx_valid && tx_ready && tx_last)
               || (state_q == ENG_ADDR_LO);
  assign done_buf_o = (state_q == ENG_IDLE) ? pick : cur_buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ENG_IDLE;
      cur_buf_q  <= 1'b0;
      byte_cnt_q <= '0;
      len_lat_q  <= '0;
      mac_hi_q   <= '0;
      mac_q      <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= done_o && req_ien_i[done_buf_o] && gie_i;
      unique case (state_q)
        ENG_IDLE: begin
          if (any_req) begin
            cur_buf_q  <= pick;
            byte_cnt_q <= '0;
            len_lat_q  <= pick_len;
            if (pick_prog)           state_q <= ENG_ADDR_HI;
            else if (pick_len != '0) state_q <= ENG_SEND;
          end
        end
        ENG_SEND: begin
          if (tx_ready) begin
            if (tx_last) state_q <= ENG_IDLE;
            else         byte_cnt_q <= byte_cnt_q + LEN_W'(1);
          end
        end
        ENG_ADDR_HI: begin
          mac_hi_q <= eng_rword;
          state_q  <= ENG_ADDR_LO;
        end
        default: begin
          mac_q   <= {mac_hi_q, eng_rword[31:16]};
          state_q <= ENG_IDLE;
        end
      endcase
    end
  end

  assign mac_o = mac_q;
  assign irq_o = irq_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_last) && $stable(byte_cnt_q)); // R4
  AST_SEND_ONLY_SEND_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(req_send_i[pick] && !req_prog_i[pick])); // R2
endmodule

// File: rtl/etx_dual_tx.sv
module etx_dual_tx #(
  parameter int BUF_WORDS = 512,
  parameter int AW        = $clog2(2 * BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_en,
  input  logic          bus_rd_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic [47:0]   station_addr,
  output logic          irq
);
  localparam int LEN_W = $clog2(4 * BUF_WORDS) + 1;

  logic [AW-1:0]            eng_raddr;
  logic [31:0]              eng_rword;
  logic                     done_w, done_buf_w;
  logic [1:0]               req_send, req_prog, req_ien;
  logic [1:0][LEN_W-1:0]    len_w;
  logic                     gie_w;

  etx_regbank #(.BUF_WORDS(BUF_WORDS), .AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .eng_raddr  (eng_raddr),
    .eng_rword  (eng_rword),
    .done_i     (done_w),
    .done_buf_i (done_buf_w),
    .req_send_o (req_send),
    .req_prog_o (req_prog),
    .req_ien_o  (req_ien),
    .len_o      (len_w),
    .gie_o      (gie_w)
  );

  etx_engine #(.BUF_WORDS(BUF_WORDS), .AW(AW), .LEN_W(LEN_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_send_i (req_send),
    .req_prog_i (req_prog),
    .req_ien_i  (req_ien),
    .len_i      (len_w),
    .gie_i      (gie_w),
    .eng_raddr  (eng_raddr),
    .eng_rword  (eng_rword),
    .done_o     (done_w),
    .done_buf_o (done_buf_w),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .mac_o      (station_addr),
    .irq_o      (irq)
  );

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(gie_w)); // R7
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done_w)); // R7
  AST_ADDR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station_addr) |-> $past(done_w)); // R5
endmodule

// File: tb/test_etx_dual_tx.sv
module test_etx_dual_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b1, tx_last;
  logic [7:0]  tx_data;
  logic [47:0] station_addr;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  int rdy_mode = 0;
  int rdy_cnt  = 0;
  logic [7:0] cap [0:63];
  int ncap = 0, nlast = 0, last_pos = -1, nirq = 0;

  always #4 clk = ~clk;

  etx_dual_tx i_etx_dual_tx (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .station_addr(station_addr), .irq(irq)
  );

  // Ready pattern: 0 always, 1 alternate, 2 one in three, 3 held low, 4 manual
  always @(posedge clk) begin
    #2;
    rdy_cnt = rdy_cnt + 1;
    case (rdy_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = rdy_cnt[0];
      2: tx_ready = (rdy_cnt % 3 == 0);
      3: tx_ready = 1'b0;
      default: ;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (ncap < 64) cap[ncap] = tx_data;
      if (tx_last) begin nlast = nlast + 1; last_pos = ncap; end
      ncap = ncap + 1;
    end
    if (rst_n && irq) nirq = nirq + 1;
  end

  function automatic logic [7:0] eb(input int b, input int i);
    return 8'((i * 37 + b * 101 + 5) & 255);
  endfunction

  function automatic logic [9:0] wa(input int b, input int w);
    return 10'(b * 512 + w);
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    bus_rd_en = 1'b1; bus_addr = a;
    @(posedge clk); #2;
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input int b);
    logic [31:0] v;
    v = 32'h1;
    while (v[0]) bus_read(wa(b, 511), v);
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic clear_cap();
    ncap = 0; nlast = 0; last_pos = -1; nirq = 0;
  endtask

  function automatic int mism(input int b, input int len, input int off);
    int m;
    m = 0;
    for (int i = 0; i < len; i++) if (cap[off + i] != eb(b, i)) m++;
    return m;
  endfunction

  task automatic load_buf(input int b);
    for (int k = 0; k < 8; k++)
      bus_write(wa(b, k), {eb(b, 4*k), eb(b, 4*k+1), eb(b, 4*k+2), eb(b, 4*k+3)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!tx_valid, "R11 tx_valid", 64'(tx_valid), 0);
    chk(!irq, "R11 irq", 64'(irq), 0);
    chk(station_addr == 0, "R11 station", station_addr, 0);
    bus_read(wa(0, 511), rd); chk(rd == 0, "R11 ctl0", rd, 0);
    bus_read(wa(1, 511), rd); chk(rd == 0, "R11 ctl1", rd, 0);
    bus_read(wa(0, 509), rd); chk(rd == 0, "R11 len0", rd, 0);
    bus_read(wa(0, 510), rd); chk(rd == 0, "R11 gie", rd, 0);

    // R1 map and readback
    bus_write(wa(0, 509), 32'hABC);
    bus_read(wa(0, 509), rd); chk(rd == 32'hABC, "R1 len0", rd, 32'hABC);
    bus_write(wa(1, 509), 32'h55);
    bus_read(wa(1, 509), rd); chk(rd == 32'h55, "R1 len1", rd, 32'h55);
    bus_write(wa(0, 510), 32'h8000_0000);
    bus_read(wa(0, 510), rd); chk(rd == 32'h8000_0000, "R1 gie", rd, 32'h8000_0000);
    bus_write(wa(1, 3), 32'h1234_5678);
    bus_read(wa(1, 3), rd); chk(rd == 32'h1234_5678, "R1 data", rd, 32'h1234_5678);

    load_buf(0);
    load_buf(1);

    // R2 R3 R4 R7 sweep over lengths, buffers and ready patterns
    for (int b = 0; b < 2; b++) begin
      for (int len = 1; len <= 16; len++) begin
        clear_cap();
        rdy_mode = len % 3;
        bus_write(wa(b, 509), 32'(len));
        bus_write(wa(b, 511), 32'h9);
        wait_idle(b);
        chk(ncap == len, "R2 byte count", 64'(ncap), 64'(len));
        chk(mism(b, len, 0) == 0 && nlast == 1 && last_pos == len - 1,
            "R3 R4 byte order/last", 64'(last_pos), 64'(len - 1));
        chk(nirq == 1, "R7 irq pulse", 64'(nirq), 1);
      end
    end
    rdy_mode = 0;

    // R6 read-back while in progress and after
    clear_cap();
    rdy_mode = 3;
    bus_write(wa(0, 509), 32'd4);
    bus_write(wa(0, 511), 32'hF09);
    bus_read(wa(0, 511), rd); chk(rd == 32'hF09, "R6 busy readback", rd, 32'hF09);
    // R8 writes while busy are ignored
    bus_write(wa(0, 511), 32'h0);
    bus_read(wa(0, 511), rd); chk(rd == 32'hF09, "R8 clear ignored", rd, 32'hF09);
    bus_write(wa(0, 511), 32'hB);
    bus_read(wa(0, 511), rd); chk(rd == 32'hF09, "R8 reprogram ignored", rd, 32'hF09);
    rdy_mode = 0;
    wait_idle(0);
    bus_read(wa(0, 511), rd); chk(rd == 32'hF08, "R6 done readback", rd, 32'hF08);
    chk(ncap == 4 && mism(0, 4, 0) == 0, "R8 single frame", 64'(ncap), 4);
    chk(nirq == 1, "R8 single irq", 64'(nirq), 1);
    clear_cap();
    bus_write(wa(1, 511), 32'hA);
    repeat (4) @(posedge clk);
    #2;
    bus_read(wa(1, 511), rd); chk(rd == 32'h8, "R6 send=0 stores zeros", rd, 32'h8);
    chk(ncap == 0 && nirq == 0, "R6 send=0 starts nothing", 64'(ncap + nirq), 0);

    // R7 gating by enables
    clear_cap();
    bus_write(wa(0, 510), 32'h0);
    bus_write(wa(0, 509), 32'd3);
    bus_write(wa(0, 511), 32'h9);
    wait_idle(0);
    chk(nirq == 0 && ncap == 3, "R7 gie off", 64'(nirq), 0);
    clear_cap();
    bus_write(wa(0, 510), 32'h7FFF_FFFF);
    bus_write(wa(1, 509), 32'd2);
    bus_write(wa(1, 511), 32'h9);
    wait_idle(1);
    chk(nirq == 0, "R7 only bit31 enables", 64'(nirq), 0);
    clear_cap();
    bus_write(wa(0, 510), 32'h8000_0000);
    bus_write(wa(0, 511), 32'h1);
    wait_idle(0);
    chk(nirq == 0, "R7 buffer enable off", 64'(nirq), 0);

    // R10 zero length
    clear_cap();
    bus_write(wa(0, 509), 32'd0);
    bus_write(wa(0, 511), 32'h9);
    wait_idle(0);
    bus_read(wa(0, 511), rd); chk(rd == 32'h8, "R10 request cleared", rd, 32'h8);
    chk(ncap == 0 && nirq == 1, "R10 no bytes, one irq", 64'(ncap), 0);

    // R9 request on the other buffer waits
    clear_cap();
    rdy_mode = 3;
    bus_write(wa(0, 509), 32'd5);
    bus_write(wa(0, 511), 32'h9);
    bus_write(wa(1, 509), 32'd3);
    bus_write(wa(1, 511), 32'h9);
    rdy_mode = 0;
    wait_idle(0);
    wait_idle(1);
    chk(ncap == 8 && mism(0, 5, 0) == 0 && mism(1, 3, 5) == 0, "R9 queued order", 64'(ncap), 8);
    chk(nirq == 2, "R9 two irqs", 64'(nirq), 2);

    // Same-cycle completion of buffer 0 and control write to buffer 1 (R9 R7)
    clear_cap();
    rdy_mode = 4;
    @(posedge clk); #2 tx_ready = 1'b0;
    bus_write(wa(0, 509), 32'd1);
    bus_write(wa(1, 509), 32'd2);
    bus_write(wa(0, 511), 32'h9);
    repeat (3) @(posedge clk);
    #2;
    tx_ready = 1'b1;
    bus_wr_en = 1'b1; bus_addr = wa(1, 511); bus_wdata = 32'h9;
    @(posedge clk); #2;
    bus_wr_en = 1'b0;
    rdy_mode = 0;
    wait_idle(1);
    chk(ncap == 3 && mism(0, 1, 0) == 0 && mism(1, 2, 1) == 0, "R9 coincident write", 64'(ncap), 3);
    chk(nirq == 2 && nlast == 2, "R7 coincident irqs", 64'(nirq), 2);

    // R5 station address load
    clear_cap();
    bus_write(wa(1, 0), 32'h02AA_BBCC);
    bus_write(wa(1, 1), 32'hDDEE_1122);
    bus_write(wa(1, 511), 32'hB);
    wait_idle(1);
    chk(station_addr == 48'h02AA_BBCC_DDEE, "R5 station", station_addr, 48'h02AA_BBCC_DDEE);
    chk(ncap == 0, "R5 no stream", 64'(ncap), 0);
    chk(nirq == 1, "R5 R7 irq", 64'(nirq), 1);
    bus_read(wa(1, 511), rd); chk(rd == 32'h8, "R5 R6 cleared", rd, 32'h8);

    summary();
    $finish;
  end
endmodule